// File: doc/BRIEF.md
# I2C Target Responder with Byte Memory

This block is a test target for a two-wire serial bus. It shares the clock and data lines with a controller. A fast system clock oversamples both lines, and the block finds START, repeated START and STOP conditions from the sampled values. A configuration input selects 7-bit or 10-bit addressing. The block acknowledges its own address and then works as a small byte store: on a write transfer the controller first sends a pointer byte and then data bytes, and on a read transfer the block returns the bytes found at the pointer.

The pointer is kept across a repeated START. A controller can therefore load the pointer in a write phase, turn the bus around with a repeated START and read back from that location within a single transaction. Two counters report how many data bytes were stored and how many were sent. The data line is open-drain. The block gives only a pull-low request, and the bench or the pad logic combines it with the controller's own drive.

Top module: `i2c_target_mem`

## Requirements
- R1: A fall of the data line while the clock line is high is a START or repeated START, and a rise while the clock is high is a STOP. Both are honoured at any bit position. A START always begins a fresh address phase, and a byte cut short by a START is not stored.
- R2: With `ten_bit_mode`=0, bits 7..1 of the first byte after a START are compared with `own_addr[6:0]`. On a match the block acknowledges, and bit 0 selects the direction: 0 means the controller writes and 1 means the block transmits.
- R3: With `ten_bit_mode`=1, a first byte of the form 11110, `own_addr[9:8]`, 0 is acknowledged. A second byte equal to `own_addr[7:0]` is then acknowledged, and the block accepts write data after it.
- R4: In 10-bit mode, a repeated START followed by 11110, `own_addr[9:8]`, 1 is acknowledged and starts transmission only when a full 10-bit match has occurred since the last STOP. Otherwise that byte is not acknowledged.
- R5: The acknowledge is `sda_pull`=1 for the whole ninth clock pulse of each matched address byte and of each write data byte. `sda_pull` changes only while the clock line is low.
- R6: The first data byte after a write address loads the pointer with its low log2(DEPTH) bits. Each later byte is stored at the pointer, and the pointer then increments, wrapping from DEPTH-1 to 0.
- R7: In transmit, the block sends the byte at the pointer, most significant bit first, and increments the pointer for each byte. A pointer set in a write phase is read back after a repeated START.
- R8: If the controller does not acknowledge a transmitted byte (data line high in the ninth pulse), the block releases the line and drives nothing until the next START.
- R9: After an address that does not match, the block acknowledges nothing and stores nothing until the next START or STOP.
- R10: `rx_bytes` increases by one for each data byte stored (the pointer byte is not counted). `tx_bytes` increases by one for each byte whose eight bits have been shifted out.
- R11: After reset, `sda_pull` is 0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| own_addr | input | 10 | Own address; bits 6..0 are used in 7-bit mode |
| sda_pull | output | 1 | 1 pulls the data line low |
| rx_bytes | output | CW | Count of data bytes stored |
| tx_bytes | output | CW | Count of bytes transmitted |

## Verification
The hardest state to reach is a 10-bit read. The block must remember that it received a full two-byte address earlier in the same transaction, then accept the short read header that follows a repeated START, and then return data from the pointer set before the turnaround. The stimulus first stores known bytes with a 10-bit write. A second transaction sends the two-byte header and a pointer, turns the bus around with a repeated START and reads. A later read header sent straight after a STOP checks that the memory of the match has been cleared. A byte cut short by a repeated START, and bus activity that continues after a non-acknowledge, cover the other paths that are hard to reach.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    TS_IDLE,
    TS_ADDR,
    TS_ADDR2,
    TS_WR,
    TS_RD
  } tgt_state_e;

  localparam logic [4:0] HDR10 = 5'b11110;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_tgt_lines.sv
module i2c_tgt_lines (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_smp,
  output logic start_det,
  output logic stop_det
);
  logic [2:0] scl_q;
  logic [2:0] sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  assign sda_smp   = sda_q[1];
  assign scl_rise  = scl_q[1] & ~scl_q[2];
  assign scl_fall  = ~scl_q[1] & scl_q[2];
  assign start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/i2c_tgt_ram.sv
module i2c_tgt_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int AW = 4,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_smp,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              ten_bit_mode,
  input  logic [9:0]        own_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_pull,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [AW-1:0]     ptr,
  output logic [CW-1:0]     rx_bytes,
  output logic [CW-1:0]     tx_bytes,
  output logic              fsm_idle
);
  tgt_state_e        st, nxt;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] tx_sh;
  logic              ptr_set;
  logic              ten_ok;
  logic              m_nack;
  logic              go_rd;

  assign fsm_idle = (st == TS_IDLE);
  assign go_rd    = (st == TS_RD) ? ~m_nack : (nxt == TS_RD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= TS_IDLE;
      nxt       <= TS_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      tx_sh     <= '0;
      ptr_set   <= 1'b0;
      ten_ok    <= 1'b0;
      m_nack    <= 1'b0;
      sda_pull  <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      ptr       <= '0;
      rx_bytes  <= '0;
      tx_bytes  <= '0;
    end else begin
      mem_we <= 1'b0;
      if (start_det) begin
        st       <= TS_ADDR;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        st       <= TS_IDLE;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
        ten_ok   <= 1'b0;
      end else if (st != TS_IDLE) begin
        if (scl_rise) begin
          bit_cnt <= bit_cnt + 4'd1;
          if (bit_cnt < 4'd8) shreg <= {shreg[6:0], sda_smp};
          if (st == TS_RD && bit_cnt == 4'd7) tx_bytes <= tx_bytes + 1'b1;
          if (st == TS_RD && bit_cnt == 4'd8) m_nack <= sda_smp;
        end else if (scl_fall) begin
          if (bit_cnt == 4'd8) begin
            case (st)
              TS_ADDR: begin
                if (!ten_bit_mode) begin
                  if (shreg[7:1] == own_addr[6:0]) begin
                    sda_pull <= 1'b1;
                    nxt      <= shreg[0] ? TS_RD : TS_WR;
                    ptr_set  <= 1'b0;
                  end else begin
                    st <= TS_IDLE;
                  end
                end else if (shreg[7:3] == HDR10 && shreg[2:1] == own_addr[9:8]) begin
                  if (!shreg[0]) begin
                    sda_pull <= 1'b1;
                    nxt      <= TS_ADDR2;
                    ten_ok   <= 1'b0;
                  end else if (ten_ok) begin
                    sda_pull <= 1'b1;
                    nxt      <= TS_RD;
                  end else begin
                    st <= TS_IDLE;
                  end
                end else begin
                  st <= TS_IDLE;
                end
              end
              TS_ADDR2: begin
                if (shreg == own_addr[7:0]) begin
                  sda_pull <= 1'b1;
                  nxt      <= TS_WR;
                  ptr_set  <= 1'b0;
                  ten_ok   <= 1'b1;
                end else begin
                  st <= TS_IDLE;
                end
              end
              TS_WR: begin
                sda_pull <= 1'b1;
                nxt      <= TS_WR;
                if (!ptr_set) begin
                  ptr     <= shreg[AW-1:0];
                  ptr_set <= 1'b1;
                end else begin
                  mem_we    <= 1'b1;
                  mem_waddr <= ptr;
                  mem_wdata <= shreg;
                  ptr       <= ptr + 1'b1;
                  rx_bytes  <= rx_bytes + 1'b1;
                end
              end
              TS_RD:   sda_pull <= 1'b0;
              default: ;
            endcase
          end else if (bit_cnt == 4'd9) begin
            bit_cnt <= '0;
            if (go_rd) begin
              st       <= TS_RD;
              sda_pull <= ~rd_data[7];
              tx_sh    <= {rd_data[6:0], 1'b0};
              ptr      <= ptr + 1'b1;
            end else if (st == TS_RD) begin
              st       <= TS_IDLE;
              sda_pull <= 1'b0;
            end else begin
              st       <= nxt;
              sda_pull <= 1'b0;
            end
          end else if (st == TS_RD && bit_cnt != 4'd0) begin
            sda_pull <= ~tx_sh[7];
            tx_sh    <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_target_mem.sv
module i2c_target_mem
  import i2c_tgt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          ten_bit_mode,
  input  logic [9:0]    own_addr,
  output logic          sda_pull,
  output logic [CW-1:0] rx_bytes,
  output logic [CW-1:0] tx_bytes
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              scl_rise, scl_fall, sda_smp, start_det, stop_det;
  logic              mem_we, fsm_idle;
  logic [AW-1:0]     mem_waddr, ptr;
  logic [BYTE_W-1:0] mem_wdata, rd_data;

  i2c_tgt_lines u_lines (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_smp   (sda_smp),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .sda_smp      (sda_smp),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .ten_bit_mode (ten_bit_mode),
    .own_addr     (own_addr),
    .rd_data      (rd_data),
    .sda_pull     (sda_pull),
    .mem_we       (mem_we),
    .mem_waddr    (mem_waddr),
    .mem_wdata    (mem_wdata),
    .ptr          (ptr),
    .rx_bytes     (rx_bytes),
    .tx_bytes     (tx_bytes),
    .fsm_idle     (fsm_idle)
  );

  i2c_tgt_ram #(.DW(BYTE_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ptr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/i2c_target_mem_chk.sv
module i2c_target_mem_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_in,
  input logic          sda_pull,
  input logic [CW-1:0] rx_bytes,
  input logic [CW-1:0] tx_bytes,
  input logic          fsm_idle
);
  AST_PULL_CHANGES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (sda_pull != $past(sda_pull)) |-> !scl_in) else $error("pull moved while clock high"); // R5

  AST_RX_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (rx_bytes == $past(rx_bytes)) || (rx_bytes == $past(rx_bytes) + 1'b1)) else $error("rx count jump"); // R10

  AST_TX_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (tx_bytes == $past(tx_bytes)) || (tx_bytes == $past(tx_bytes) + 1'b1)) else $error("tx count jump"); // R10

  AST_RX_ON_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (rx_bytes != $past(rx_bytes)) |-> !scl_in) else $error("rx count moved with clock high"); // R10

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    fsm_idle |-> !sda_pull) else $error("line driven while ignoring bus"); // R8
endmodule

bind i2c_target_mem i2c_target_mem_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_in   (scl_in),
  .sda_pull (sda_pull),
  .rx_bytes (rx_bytes),
  .tx_bytes (tx_bytes),
  .fsm_idle (fsm_idle)
);

// File: tb/i2c_target_mem_tb.sv
module i2c_target_mem_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q  = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          scl_m = 1'b1;
  logic          sda_m_low = 1'b0;
  logic          ten_bit_mode = 1'b0;
  logic [9:0]    own_addr = 10'h02A;
  logic          sda_pull;
  logic [CW-1:0] rx_bytes, tx_bytes;
  logic          sda_line;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       byte_seen;
  logic [7:0] obs_byte;
  logic [7:0] mon_exp;
  string      mon_tag;
  logic [7:0] tmp;
  bit         ak;

  assign sda_line = !(sda_m_low || sda_pull);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_target_mem #(.DEPTH(16), .CW(CW)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .scl_in       (scl_m),
    .sda_in       (sda_line),
    .ten_bit_mode (ten_bit_mode),
    .own_addr     (own_addr),
    .sda_pull     (sda_pull),
    .rx_bytes     (rx_bytes),
    .tx_bytes     (tx_bytes)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic tick();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m_low = 1'b0; tick();
    scl_m = 1'b1;     tick();
    sda_m_low = 1'b1; tick();
    scl_m = 1'b0;     tick();
  endtask

  task automatic bus_stop();
    sda_m_low = 1'b1; tick();
    scl_m = 1'b1;     tick();
    sda_m_low = 1'b0; tick(); tick();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m_low = !b[i]; tick();
      scl_m = 1'b1; tick(); tick();
      scl_m = 1'b0; tick();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m_low = 1'b0; tick();
    scl_m = 1'b1; tick();
    acked = sda_pull && !sda_line;
    tick();
    scl_m = 1'b0; tick();
  endtask

  task automatic send_chk(input logic [7:0] b, input bit exp_ack, input string req);
    bit a;
    send_byte(b, a);
    chk(a == exp_ack, req, int'(a), int'(exp_ack));
  endtask

  task automatic recv_byte(input bit m_ack, output logic [7:0] b);
    sda_m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick();
      scl_m = 1'b1; tick();
      b[i] = sda_line; tick();
      scl_m = 1'b0;
    end
    tick();
    sda_m_low = m_ack; tick();
    scl_m = 1'b1; tick(); tick();
    scl_m = 1'b0; tick();
    sda_m_low = 1'b0;
  endtask

  task automatic read_exp(input logic [7:0] e, input bit m_ack, input string req);
    logic [7:0] b;
    exp_q.push_back(e);
    tag_q.push_back(req);
    recv_byte(m_ack, b);
    obs_byte = b;
    -> byte_seen;
  endtask

  initial begin
    forever begin
      @(byte_seen);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", int'(obs_byte), 0);
      end else begin
        mon_exp = exp_q.pop_front();
        mon_tag = tag_q.pop_front();
        chk(obs_byte == mon_exp, mon_tag, int'(obs_byte), int'(mon_exp));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    rst = 1'b0;
    tick();
    // R11 reset state
    chk(sda_pull == 1'b0, "R11", int'(sda_pull), 0);
    chk(rx_bytes == 0, "R11", int'(rx_bytes), 0);
    chk(tx_bytes == 0, "R11", int'(tx_bytes), 0);

    // R2 R6: 7-bit write, pointer 5, three data bytes
    bus_start();
    send_chk(8'h54, 1'b1, "R2");
    send_chk(8'h05, 1'b1, "R5");
    send_chk(8'hA1, 1'b1, "R5");
    send_chk(8'hB2, 1'b1, "R6");
    send_chk(8'hC3, 1'b1, "R6");
    bus_stop();
    chk(rx_bytes == 3, "R10", int'(rx_bytes), 3);

    // R7 R1: pointer write, repeated START, read back
    bus_start();
    send_chk(8'h54, 1'b1, "R2");
    send_chk(8'h05, 1'b1, "R6");
    bus_start();
    send_chk(8'h55, 1'b1, "R1");
    read_exp(8'hA1, 1'b1, "R7");
    read_exp(8'hB2, 1'b1, "R7");
    read_exp(8'hC3, 1'b0, "R7");
    bus_stop();
    chk(tx_bytes == 3, "R10", int'(tx_bytes), 3);

    // R8: NACK then more clocks without START
    bus_start();
    send_chk(8'h54, 1'b1, "R2");
    send_chk(8'h06, 1'b1, "R6");
    bus_start();
    send_chk(8'h55, 1'b1, "R2");
    read_exp(8'hB2, 1'b0, "R8");
    recv_byte(1'b0, tmp);
    chk(tmp == 8'hFF, "R8", int'(tmp), 8'hFF);
    bus_stop();
    chk(tx_bytes == 4, "R8", int'(tx_bytes), 4);

    // R9: wrong address, later matching byte ignored
    bus_start();
    send_chk(8'h56, 1'b0, "R9");
    send_chk(8'h54, 1'b0, "R9");
    send_chk(8'h99, 1'b0, "R9");
    bus_stop();
    chk(rx_bytes == 3, "R9", int'(rx_bytes), 3);
    bus_start();
    send_chk(8'h54, 1'b1, "R2");
    send_chk(8'h05, 1'b1, "R6");
    bus_start();
    send_chk(8'h55, 1'b1, "R2");
    read_exp(8'hA1, 1'b0, "R9");
    bus_stop();

    // R6 wrap: write at 15 then 0
    bus_start();
    send_chk(8'h54, 1'b1, "R2");
    send_chk(8'h1F, 1'b1, "R6");
    send_chk(8'hD4, 1'b1, "R6");
    send_chk(8'hE5, 1'b1, "R6");
    bus_stop();
    chk(rx_bytes == 5, "R10", int'(rx_bytes), 5);
    bus_start();
    send_chk(8'h54, 1'b1, "R2");
    send_chk(8'h0F, 1'b1, "R6");
    bus_start();
    send_chk(8'h55, 1'b1, "R2");
    read_exp(8'hD4, 1'b1, "R6");
    read_exp(8'hE5, 1'b0, "R6");
    bus_stop();

    // R1: byte cut by repeated START is not stored
    bus_start();
    send_chk(8'h54, 1'b1, "R2");
    send_chk(8'h02, 1'b1, "R6");
    send_bits(8'hF0, 3);
    bus_start();
    send_chk(8'h54, 1'b1, "R1");
    send_chk(8'h02, 1'b1, "R1");
    send_chk(8'h77, 1'b1, "R1");
    bus_stop();
    chk(rx_bytes == 6, "R1", int'(rx_bytes), 6);
    bus_start();
    send_chk(8'h54, 1'b1, "R2");
    send_chk(8'h02, 1'b1, "R6");
    bus_start();
    send_chk(8'h55, 1'b1, "R2");
    read_exp(8'h77, 1'b0, "R1");
    bus_stop();

    // R3 R4: 10-bit addressing, own 0x2C5
    ten_bit_mode = 1'b1;
    own_addr = 10'h2C5;
    tick();
    bus_start();
    send_chk(8'hF4, 1'b1, "R3");
    send_chk(8'hC5, 1'b1, "R3");
    send_chk(8'h08, 1'b1, "R3");
    send_chk(8'h3C, 1'b1, "R3");
    send_chk(8'h4D, 1'b1, "R3");
    bus_stop();
    chk(rx_bytes == 8, "R10", int'(rx_bytes), 8);
    bus_start();
    send_chk(8'hF4, 1'b1, "R3");
    send_chk(8'hC5, 1'b1, "R3");
    send_chk(8'h08, 1'b1, "R3");
    bus_start();
    send_chk(8'hF5, 1'b1, "R4");
    read_exp(8'h3C, 1'b1, "R4");
    read_exp(8'h4D, 1'b0, "R4");
    bus_stop();
    bus_start();
    send_chk(8'hF5, 1'b0, "R4");
    bus_stop();
    bus_start();
    send_chk(8'hF4, 1'b1, "R3");
    send_chk(8'hC6, 1'b0, "R3");
    bus_stop();

    tick();
    chk(tx_bytes == 10, "R10", int'(tx_bytes), 10);
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule